// File: doc/BRIEF.md
# SDRAM Read Data Return Scheduler

This block sits on the controller side of an SDRAM interface. It sees each command the controller issues (read, write, burst terminate, precharge with a bank number or to all banks, no-op) together with the programmed CAS latency and burst length. From these it predicts, cycle by cycle, whether the memory is returning read data, which read that data belongs to, and which beat of the burst it is. It takes into account every way a burst can be cut short: a later read, a terminate, or a precharge to the bank being read.

The block also produces the data-mask (DQM) level the controller needs when it wants to break into a read with a write. Masking reaches read data two cycles late but acts on write data at once. The block therefore raises the mask while a write is pending and read data is still due. It permits the write only after the mask has been high for the two cycles before it, and drops the mask on the write cycle itself. A beat that the mask hides is reported as not valid.

Top module: `rdret_sched`

## Requirements
- R1: The first beat of a read is valid exactly `cas_lat` cycles after the cycle in which the read command is presented. The following beats come on consecutive cycles with `rd_beat` counting 0 up to BL-1 and `rd_id` equal to the read's tag. BL = 2^`bl_code` (`bl_code` 0..3 gives 1, 2, 4, 8).
- R2: `rd_last` is high on the beat with index BL-1, and no beat of that burst follows it.
- R3: A read issued k cycles after an earlier read (k < BL) ends the earlier burst after k beats. `rd_last` marks the earlier burst's final delivered beat, and the new burst begins with beat 0 on the next cycle.
- R4: A burst terminate (op 3), or a precharge (op 4) to the bank of the burst or with `cmd_all` set, ends the burst. No beat is valid from `cas_lat` cycles after that command, and the beat just before carries `rd_last`.
- R5: A precharge to a different bank with `cmd_all` low leaves the burst untouched.
- R6: When `dqm` is high in cycle t, `rd_valid` is low in cycle t+2, even if a beat is due then.
- R7: While `wr_pend` is high and read data is still due, `dqm` is high, except in a cycle carrying a write (op 2), where it is low. `wr_ok` is high while data is due only if `dqm` was high in both of the two preceding cycles. With no read data due, `dqm` is low and `wr_ok` is high.
- R8: A write ends all read data from its own cycle on, including reads not yet returning.
- R9: After reset `rd_valid` and `dqm` are low and `wr_ok` is high. Any `cas_lat` from 2 to 8 is honoured.
- R10: `cas_lat` does not change in a cycle that follows one with read data due.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_op | input | 3 | 0 no-op, 1 read, 2 write, 3 burst terminate, 4 precharge |
| cmd_bank | input | BANK_W | Bank of a read or precharge |
| cmd_all | input | 1 | Precharge applies to all banks |
| cmd_id | input | ID_W | Tag of a read |
| cas_lat | input | CL_W | CAS latency in cycles, 2..MAX_CL |
| bl_code | input | BL_W | log2 of burst length |
| wr_pend | input | 1 | Controller wants to issue a write |
| rd_valid | output | 1 | Read data returned this cycle |
| rd_id | output | ID_W | Tag of the read owning this beat |
| rd_beat | output | BEAT_W | Beat index within the burst |
| rd_last | output | 1 | Final beat of this burst |
| dqm | output | 1 | Data mask level to drive this cycle |
| wr_ok | output | 1 | A write may be issued this cycle |

## Verification
The hardest case to reach is a read hidden by the mask. It needs a beat due exactly two cycles after a cycle in which the mask was high, while no write follows to cut the burst anyway. The bench gets there by raising `wr_pend` for a single cycle in the middle of an 8-beat burst and then dropping it. It expects one missing beat two cycles later and the next beat back on time. The write break-in case is driven the same way. The bench holds the request until `wr_ok` rises, then issues the write and checks that nothing from that read returns afterwards.

// File: rtl/rdret_pkg.sv
`timescale 1ns/1ps
package rdret_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_READ  = 3'd1,
    OP_WRITE = 3'd2,
    OP_TERM  = 3'd3,
    OP_PRE   = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_READ = 2'd1,
    EV_TERM = 2'd2,
    EV_PRE  = 2'd3
  } ev_e;
endpackage

// File: rtl/rdret_cmd_pipe.sv
`timescale 1ns/1ps
module rdret_cmd_pipe
  import rdret_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int BANK_W = 2,
  parameter int MAX_CL = 8,
  localparam int CL_W  = $clog2(MAX_CL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op,
  input  logic [BANK_W-1:0] bank,
  input  logic              all_bk,
  input  logic [ID_W-1:0]   id,
  input  logic [CL_W-1:0]   cas_lat,
  output ev_e               arr_ev,
  output logic [ID_W-1:0]   arr_id,
  output logic [BANK_W-1:0] arr_bank,
  output logic              arr_all,
  output ev_e               nxt_ev,
  output logic [BANK_W-1:0] nxt_bank,
  output logic              nxt_all,
  output logic              rd_inflight
);
  ev_e               st_ev   [1:MAX_CL];
  logic [ID_W-1:0]   st_id   [1:MAX_CL];
  logic [BANK_W-1:0] st_bank [1:MAX_CL];
  logic              st_all  [1:MAX_CL];

  ev_e  ev_in;
  logic wr_clear;

  always_comb begin
    wr_clear = (op == OP_WRITE);
    case (op)
      OP_READ: ev_in = EV_READ;
      OP_TERM: ev_in = EV_TERM;
      OP_PRE:  ev_in = EV_PRE;
      default: ev_in = EV_NONE;
    endcase
  end

  // shift stages; a write wipes every pending event
  genvar g;
  generate
    for (g = 1; g <= MAX_CL; g++) begin : g_stage
      ev_e               ev_n;
      logic [ID_W-1:0]   id_n;
      logic [BANK_W-1:0] bank_n;
      logic              all_n;
      if (g == 1) begin : g_head
        always_comb begin
          ev_n   = wr_clear ? EV_NONE : ev_in;
          id_n   = id;
          bank_n = bank;
          all_n  = all_bk;
        end
      end else begin : g_body
        always_comb begin
          ev_n   = wr_clear ? EV_NONE : st_ev[g-1];
          id_n   = st_id[g-1];
          bank_n = st_bank[g-1];
          all_n  = st_all[g-1];
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st_ev[g]   <= EV_NONE;
          st_id[g]   <= '0;
          st_bank[g] <= '0;
          st_all[g]  <= 1'b0;
        end else begin
          st_ev[g]   <= ev_n;
          st_id[g]   <= id_n;
          st_bank[g] <= bank_n;
          st_all[g]  <= all_n;
        end
      end
    end
  endgenerate

  always_comb begin
    arr_ev      = EV_NONE;
    arr_id      = '0;
    arr_bank    = '0;
    arr_all     = 1'b0;
    nxt_ev      = EV_NONE;
    nxt_bank    = '0;
    nxt_all     = 1'b0;
    rd_inflight = 1'b0;
    for (int k = 1; k <= MAX_CL; k++) begin
      if (CL_W'(k) == cas_lat) begin
        arr_ev   = st_ev[k];
        arr_id   = st_id[k];
        arr_bank = st_bank[k];
        arr_all  = st_all[k];
      end
      if (CL_W'(k + 1) == cas_lat) begin
        nxt_ev   = st_ev[k];
        nxt_bank = st_bank[k];
        nxt_all  = st_all[k];
      end
      if (CL_W'(k) <= cas_lat && st_ev[k] == EV_READ) rd_inflight = 1'b1;
    end
  end

  // R8: the cycle after a write nothing pending may arrive
  assert_write_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op == OP_WRITE) |-> (arr_ev == EV_NONE && nxt_ev == EV_NONE));
endmodule

// File: rtl/rdret_burst.sv
`timescale 1ns/1ps
module rdret_burst
  import rdret_pkg::*;
#(
  parameter int ID_W       = 4,
  parameter int BANK_W     = 2,
  parameter int MAX_BL_LOG = 3,
  localparam int BEAT_W    = MAX_BL_LOG,
  localparam int BL_W      = $clog2(MAX_BL_LOG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_now,
  input  logic [BL_W-1:0]   bl_code,
  input  ev_e               arr_ev,
  input  logic [ID_W-1:0]   arr_id,
  input  logic [BANK_W-1:0] arr_bank,
  input  logic              arr_all,
  input  ev_e               nxt_ev,
  input  logic [BANK_W-1:0] nxt_bank,
  input  logic              nxt_all,
  output logic              sched,
  output logic [ID_W-1:0]   s_id,
  output logic [BEAT_W-1:0] s_beat,
  output logic              s_last,
  output logic              act
);
  logic              act_q, act_n;
  logic [ID_W-1:0]   id_q, id_n;
  logic [BEAT_W-1:0] beat_q, beat_n;
  logic [BANK_W-1:0] bank_q, bank_n;
  logic [BANK_W-1:0] s_bank;
  logic [BEAT_W-1:0] bl_max;
  logic              hit_pre, cut_next;

  always_comb begin
    bl_max  = BEAT_W'((1 << bl_code) - 1);
    hit_pre = (arr_ev == EV_PRE) && act_q && (arr_all || arr_bank == bank_q);
    sched   = 1'b0;
    s_id    = id_q;
    s_beat  = beat_q;
    s_bank  = bank_q;
    act_n   = act_q;
    id_n    = id_q;
    beat_n  = beat_q;
    bank_n  = bank_q;
    if (wr_now) begin
      act_n = 1'b0;
    end else if (arr_ev == EV_READ) begin
      sched  = 1'b1;
      s_id   = arr_id;
      s_beat = '0;
      s_bank = arr_bank;
      act_n  = (bl_max != '0);
      id_n   = arr_id;
      bank_n = arr_bank;
      beat_n = BEAT_W'(1);
    end else if (arr_ev == EV_TERM || hit_pre) begin
      act_n = 1'b0;
    end else if (act_q) begin
      sched = 1'b1;
      if (beat_q == bl_max) act_n = 1'b0;
      else beat_n = beat_q + 1'b1;
    end
    cut_next = (nxt_ev == EV_READ) || (nxt_ev == EV_TERM) ||
               ((nxt_ev == EV_PRE) && (nxt_all || nxt_bank == s_bank));
    s_last = sched && ((s_beat == bl_max) || cut_next);
    act    = act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      id_q   <= '0;
      beat_q <= '0;
      bank_q <= '0;
    end else begin
      act_q <= act_n;
      if (act_n) begin
        id_q   <= id_n;
        beat_q <= beat_n;
        bank_q <= bank_n;
      end
    end
  end

  // R1: a continuing beat follows its predecessor of the same read
  assert_beat_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sched && s_beat != '0) |-> ($past(sched) && s_beat == $past(s_beat) + 1'b1
                                 && s_id == $past(s_id)));
  // R2: after a final beat only a fresh burst may appear
  assert_last_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    s_last |=> (!sched || s_beat == '0));
  // R8: nothing is returned in a write cycle
  assert_write_cut_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_now |-> !sched);
endmodule

// File: rtl/rdret_mask.sv
`timescale 1ns/1ps
module rdret_mask (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_pend,
  input  logic wr_now,
  input  logic busy,
  input  logic sched,
  output logic dqm,
  output logic wr_ok,
  output logic rd_valid
);
  logic       dqm_d1, dqm_d2;
  logic [1:0] hi_cnt, hi_cnt_n;

  always_comb begin
    dqm      = wr_pend && busy && !wr_now;
    wr_ok    = !busy || (hi_cnt == 2'd2);
    rd_valid = sched && !dqm_d2;
    if (!dqm)                 hi_cnt_n = 2'd0;
    else if (hi_cnt != 2'd2)  hi_cnt_n = hi_cnt + 2'd1;
    else                      hi_cnt_n = hi_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dqm_d1 <= 1'b0;
      dqm_d2 <= 1'b0;
      hi_cnt <= 2'd0;
    end else begin
      dqm_d1 <= dqm;
      dqm_d2 <= dqm_d1;
      hi_cnt <= hi_cnt_n;
    end
  end

  // R6: a mask two cycles ago hides the beat
  assert_mask_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dqm, 2) |-> !rd_valid);
  // R7: write permitted during due data only after two masked cycles
  assert_wr_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && busy) |-> ($past(dqm) && $past(dqm, 2)));
endmodule

// File: rtl/rdret_sched.sv
`timescale 1ns/1ps
module rdret_sched
  import rdret_pkg::*;
#(
  parameter int ID_W       = 4,
  parameter int BANK_W     = 2,
  parameter int MAX_CL     = 8,
  parameter int MAX_BL_LOG = 3,
  localparam int CL_W      = $clog2(MAX_CL + 1),
  localparam int BL_W      = $clog2(MAX_BL_LOG + 1),
  localparam int BEAT_W    = MAX_BL_LOG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd_op,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic              cmd_all,
  input  logic [ID_W-1:0]   cmd_id,
  input  logic [CL_W-1:0]   cas_lat,
  input  logic [BL_W-1:0]   bl_code,
  input  logic              wr_pend,
  output logic              rd_valid,
  output logic [ID_W-1:0]   rd_id,
  output logic [BEAT_W-1:0] rd_beat,
  output logic              rd_last,
  output logic              dqm,
  output logic              wr_ok
);
  ev_e               arr_ev, nxt_ev;
  logic [ID_W-1:0]   arr_id;
  logic [BANK_W-1:0] arr_bank, nxt_bank;
  logic              arr_all, nxt_all, rd_inflight;
  logic              sched, s_last, act, busy, wr_now;

  assign wr_now = (cmd_op == OP_WRITE);
  assign busy   = rd_inflight || act;

  rdret_cmd_pipe #(.ID_W(ID_W), .BANK_W(BANK_W), .MAX_CL(MAX_CL)) u_pipe (
    .clk(clk), .rst_n(rst_n), .op(cmd_op), .bank(cmd_bank), .all_bk(cmd_all),
    .id(cmd_id), .cas_lat(cas_lat), .arr_ev(arr_ev), .arr_id(arr_id),
    .arr_bank(arr_bank), .arr_all(arr_all), .nxt_ev(nxt_ev),
    .nxt_bank(nxt_bank), .nxt_all(nxt_all), .rd_inflight(rd_inflight)
  );

  rdret_burst #(.ID_W(ID_W), .BANK_W(BANK_W), .MAX_BL_LOG(MAX_BL_LOG)) u_burst (
    .clk(clk), .rst_n(rst_n), .wr_now(wr_now), .bl_code(bl_code),
    .arr_ev(arr_ev), .arr_id(arr_id), .arr_bank(arr_bank), .arr_all(arr_all),
    .nxt_ev(nxt_ev), .nxt_bank(nxt_bank), .nxt_all(nxt_all),
    .sched(sched), .s_id(rd_id), .s_beat(rd_beat), .s_last(s_last), .act(act)
  );

  rdret_mask u_mask (
    .clk(clk), .rst_n(rst_n), .wr_pend(wr_pend), .wr_now(wr_now),
    .busy(busy), .sched(sched), .dqm(dqm), .wr_ok(wr_ok), .rd_valid(rd_valid)
  );

  assign rd_last = s_last && rd_valid;

  // R9: programmed latency within the supported range
  assert_cl_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_lat >= CL_W'(2)) && (cas_lat <= CL_W'(MAX_CL)));
  // R10: latency held while read data is due
  assert_cl_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> $stable(cas_lat));
endmodule

// File: tb/sim_rdret_sched.sv
`timescale 1ns/1ps
module sim_rdret_sched;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] cmd_op;
  logic [1:0] cmd_bank;
  logic       cmd_all;
  logic [3:0] cmd_id;
  logic [3:0] cas_lat;
  logic [1:0] bl_code;
  logic       wr_pend;
  logic       rd_valid, rd_last, dqm, wr_ok;
  logic [3:0] rd_id;
  logic [2:0] rd_beat;

  int n_chk = 0;
  int n_bad = 0;
  int cyc;
  logic       lv [0:63];
  logic [3:0] lid[0:63];
  logic [2:0] lbt[0:63];
  logic       lls[0:63];
  logic       ldq[0:63];
  logic       lok[0:63];

  always #2.5 clk = ~clk;

  rdret_sched u0 (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
    .cmd_all(cmd_all), .cmd_id(cmd_id), .cas_lat(cas_lat), .bl_code(bl_code),
    .wr_pend(wr_pend), .rd_valid(rd_valid), .rd_id(rd_id), .rd_beat(rd_beat),
    .rd_last(rd_last), .dqm(dqm), .wr_ok(wr_ok)
  );

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual running expected done");
    report();
  end

  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act_v, exp_v);
    end
  endtask

  task automatic tick(input logic [2:0] o, input logic [1:0] b, input logic a,
                      input logic [3:0] i, input logic wp);
    @(negedge clk);
    cmd_op = o; cmd_bank = b; cmd_all = a; cmd_id = i; wr_pend = wp;
    #1;
    lv[cyc] = rd_valid; lid[cyc] = rd_id; lbt[cyc] = rd_beat;
    lls[cyc] = rd_last; ldq[cyc] = dqm; lok[cyc] = wr_ok;
    cyc++;
  endtask

  task automatic nops(input int n);
    for (int k = 0; k < n; k++) tick(3'd0, 2'd0, 1'b0, 4'd0, 1'b0);
  endtask

  task automatic start(input int cl, input int blc);
    nops(12);
    @(negedge clk);
    cas_lat = 4'(cl); bl_code = 2'(blc);
    cyc = 0;
  endtask

  // expected beat (v=1) or an empty cycle (v=0)
  task automatic beat(input int c, input bit v, input int id, input int bt,
                      input bit last, input string req);
    chk(lv[c] == v, {req, " valid"}, int'(lv[c]), int'(v));
    if (v && lv[c]) begin
      chk(lid[c] == 4'(id), {req, " id"}, int'(lid[c]), id);
      chk(lbt[c] == 3'(bt), {req, " beat"}, int'(lbt[c]), bt);
      chk(lls[c] == last, {req, " last"}, int'(lls[c]), int'(last));
    end
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk(rd_valid == 1'b0, "R9 reset valid", int'(rd_valid), 0);
    chk(dqm == 1'b0, "R9 reset dqm", int'(dqm), 0);
    chk(wr_ok == 1'b1, "R9 reset wr_ok", int'(wr_ok), 1);
  endtask

  task automatic t_single();
    start(3, 2);
    tick(3'd1, 2'd0, 1'b0, 4'd1, 1'b0); nops(9);
    for (int c = 0; c < 3; c++) beat(c, 0, 0, 0, 0, "R1 early");
    for (int c = 3; c < 7; c++) beat(c, 1, 1, c - 3, c == 6, "R1 R2 burst");
    beat(7, 0, 0, 0, 0, "R2 after end");
  endtask

  task automatic t_read_read();
    start(3, 2);
    tick(3'd1, 2'd0, 1'b0, 4'd1, 1'b0); nops(1);
    tick(3'd1, 2'd1, 1'b0, 4'd2, 1'b0); nops(9);
    beat(3, 1, 1, 0, 0, "R3 first");
    beat(4, 1, 1, 1, 1, "R3 cut last");
    for (int c = 5; c < 9; c++) beat(c, 1, 2, c - 5, c == 8, "R3 second");
    beat(9, 0, 0, 0, 0, "R3 tail");
  endtask

  task automatic t_stop(input logic [2:0] o, input logic [1:0] b, input logic a,
                        input bit cuts, input string req);
    start(3, 2);
    tick(3'd1, 2'd1, 1'b0, 4'd3, 1'b0); nops(1);
    tick(o, b, a, 4'd0, 1'b0); nops(8);
    beat(3, 1, 3, 0, 0, req);
    beat(4, 1, 3, 1, cuts, req);
    if (cuts) begin
      beat(5, 0, 0, 0, 0, req);
      beat(6, 0, 0, 0, 0, req);
    end else begin
      beat(5, 1, 3, 2, 0, req);
      beat(6, 1, 3, 3, 1, req);
    end
  endtask

  task automatic t_latency();
    start(2, 0);
    tick(3'd1, 2'd0, 1'b0, 4'd4, 1'b0); nops(4);
    beat(1, 0, 0, 0, 0, "R9 cl2 early");
    beat(2, 1, 4, 0, 1, "R9 cl2 bl1");
    beat(3, 0, 0, 0, 0, "R9 cl2 after");
    start(8, 3);
    tick(3'd1, 2'd2, 1'b0, 4'd5, 1'b0); nops(18);
    beat(7, 0, 0, 0, 0, "R9 cl8 early");
    for (int c = 8; c < 16; c++) beat(c, 1, 5, c - 8, c == 15, "R9 cl8 bl8");
    beat(16, 0, 0, 0, 0, "R9 cl8 after");
  endtask

  task automatic t_mask_only();
    start(3, 3);
    tick(3'd1, 2'd0, 1'b0, 4'd6, 1'b0); nops(3);
    tick(3'd0, 2'd0, 1'b0, 4'd0, 1'b1); nops(8);
    chk(ldq[4] == 1'b1, "R7 dqm raised", int'(ldq[4]), 1);
    chk(lok[4] == 1'b0, "R7 wr_ok held", int'(lok[4]), 0);
    chk(ldq[5] == 1'b0, "R7 dqm dropped", int'(ldq[5]), 0);
    beat(5, 1, 6, 2, 0, "R6 before mask");
    beat(6, 0, 0, 0, 0, "R6 masked beat");
    beat(7, 1, 6, 4, 0, "R6 after mask");
    beat(10, 1, 6, 7, 1, "R6 end");
  endtask

  task automatic t_write_break();
    start(3, 3);
    tick(3'd1, 2'd0, 1'b0, 4'd7, 1'b0); nops(3);
    tick(3'd0, 2'd0, 1'b0, 4'd0, 1'b1);
    tick(3'd0, 2'd0, 1'b0, 4'd0, 1'b1);
    tick(3'd2, 2'd0, 1'b0, 4'd0, 1'b1); nops(8);
    chk(lok[4] == 1'b0 && lok[5] == 1'b0, "R7 wr_ok early", int'(lok[5]), 0);
    chk(lok[6] == 1'b1, "R7 wr_ok granted", int'(lok[6]), 1);
    chk(ldq[4] && ldq[5], "R7 dqm before write", int'(ldq[5]), 1);
    chk(ldq[6] == 1'b0, "R7 dqm on write", int'(ldq[6]), 0);
    for (int c = 3; c < 6; c++) beat(c, 1, 7, c - 3, 0, "R8 before write");
    for (int c = 6; c < 13; c++) beat(c, 0, 0, 0, 0, "R8 after write");
  endtask

  task automatic t_idle_req();
    start(3, 2);
    tick(3'd0, 2'd0, 1'b0, 4'd0, 1'b1);
    chk(ldq[0] == 1'b0, "R7 idle dqm", int'(ldq[0]), 0);
    chk(lok[0] == 1'b1, "R7 idle wr_ok", int'(lok[0]), 1);
  endtask

  task automatic t_inflight_write();
    start(3, 2);
    tick(3'd1, 2'd0, 1'b0, 4'd8, 1'b0);
    tick(3'd2, 2'd0, 1'b0, 4'd0, 1'b0); nops(8);
    for (int c = 1; c < 9; c++) beat(c, 0, 0, 0, 0, "R8 pending read dropped");
  endtask

  initial begin
    rst_n = 1'b0; cmd_op = 3'd0; cmd_bank = 2'd0; cmd_all = 1'b0; cmd_id = 4'd0;
    cas_lat = 4'd3; bl_code = 2'd2; wr_pend = 1'b0; cyc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_single();
    t_read_read();
    t_stop(3'd3, 2'd0, 1'b0, 1'b1, "R4 terminate");
    t_stop(3'd4, 2'd1, 1'b0, 1'b1, "R4 precharge same bank");
    t_stop(3'd4, 2'd3, 1'b1, 1'b1, "R4 precharge all");
    t_stop(3'd4, 2'd2, 1'b0, 1'b0, "R5 precharge other bank");
    t_latency();
    t_mask_only();
    t_write_break();
    t_idle_req();
    t_inflight_write();
    nops(4);
    report();
  end
endmodule